// File: doc/BRIEF.md
# I2C Slave Address Matcher with General Call

This block is the receive front end of an I2C slave. It samples the bus clock and data lines through synchronisers and finds Start and Stop conditions. After each Start it collects the first byte and classifies it against a programmed own address and against the all-zero general call address. For a matching address it acknowledges by pulling the data line low during the ninth clock, then accepts data bytes into a one-byte receive buffer. Software sees a buffer-full flag, an overflow flag, an update-address flag and an interrupt flag. It clears them with a buffer read strobe and an interrupt clear strobe.

Both 7-bit and 10-bit addressing are supported. In 10-bit mode the first address byte carries the fixed `11110` prefix and the two top address bits. A match on it raises the update-address flag, so that software can load the low address byte into the own-address register before the second byte arrives. A general call, when enabled, bypasses the second address byte in either mode. Software tells a general call from a device-specific address by reading 0x00 from the buffer.

Top module: `i2c_gc_slave`

## Requirements
- R1: After reset, rx_buf is 0x00, buf_full, overflow, upd_addr and irq are 0, and sda_oe is 0 (data line released).
- R2: A Start (SDA falling while SCL high) at any point aborts the byte in progress and restarts address reception. A Stop (SDA rising while SCL high) returns the block to idle with sda_oe low. In idle, bytes clocked without a new Start are not acknowledged.
- R3: In 7-bit mode (ten_bit=0), a first byte whose bits [7:1] equal own_addr[7:1] and whose bit 0 (R/W) is 0 is acknowledged. This means sda_oe is high while SCL is high in the ninth clock. At the eighth rising SCL edge the byte is copied into rx_buf and buf_full is set.
- R4: A first byte that does not match, including a matching address with R/W=1, is not acknowledged and leaves rx_buf, buf_full and irq unchanged. All following bytes are ignored until the next Start.
- R5: The first byte 0x00 is a general call. It is acknowledged and loaded into rx_buf only when gc_enable is 1. With gc_enable at 0 it is handled as a non-matching address.
- R6: irq is set on the falling SCL edge that ends the ninth clock of every byte the block has accepted (address or data). It stays set until irq_clr is pulsed.
- R7: A pulse of buf_rd clears buf_full.
- R8: A data byte that completes while buf_full is 1 sets overflow, is not acknowledged, and leaves rx_buf unchanged. overflow is cleared by irq_clr.
- R9: In 10-bit mode (ten_bit=1), a first byte matching the R3 rule and carrying the prefix 11110 in bits [7:3] is acknowledged and sets upd_addr. upd_addr clears when the own_addr value changes or at the next Start. The second byte must equal all eight bits of own_addr to be acknowledged and loaded. Bytes after it are data.
- R10: In 10-bit mode, an enabled general call leaves upd_addr at 0. The next byte is received as data and is not compared as an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| own_addr | input | 8 | Own-address register; bits [7:1] hold the 7-bit address or 10-bit high part, all 8 bits the 10-bit low part |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| gc_enable | input | 1 | 1 enables general call recognition |
| buf_rd | input | 1 | One-cycle receive buffer read strobe |
| irq_clr | input | 1 | One-cycle clear of irq and overflow |
| rx_buf | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | Data byte lost because the buffer was full |
| upd_addr | output | 1 | Own address must be reloaded for the second 10-bit byte |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest path to reach from the ports is the 10-bit second address byte. Without clock stretching, software has to change own_addr in the short gap between the first acknowledge and the eighth clock of the next byte. The bench does this by changing own_addr right after the first byte's task returns, while SCL is held low. It then checks that upd_addr dropped and that the second byte is acknowledged only against the new value. The overflow case is reached by deliberately not pulsing buf_rd between two data bytes. A Start and a Stop are also issued in the middle of a byte to check that partial bytes are dropped.

// File: rtl/i2c_gc_pkg.sv
`timescale 1ns/1ps
package i2c_gc_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_DATA,
        ST_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        CL_NONE,
        CL_GC,
        CL_OWN7,
        CL_OWN10HI
    } addr_class_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   rxbuf;
        logic                full;
        logic                ovf;
        logic                ua;
        logic                irq;
        logic                ack_arm;
        logic                irq_arm;
        logic                oe;
        logic [BYTE_W-1:0]   own_seen;
    } core_s;

endpackage

// File: rtl/i2c_gc_sync.sv
`timescale 1ns/1ps
module i2c_gc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_sh_d, scl_sh_q;
    logic [DEPTH-1:0] sda_sh_d, sda_sh_q;
    logic             scl_prev, sda_prev;

    always_comb begin
        scl_sh_d = {scl_sh_q[DEPTH-2:0], scl_i};
        sda_sh_d = {sda_sh_q[DEPTH-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
        end
    end

    assign scl_lvl   = scl_sh_q[STAGES-1];
    assign sda_lvl   = sda_sh_q[STAGES-1];
    assign scl_prev  = scl_sh_q[STAGES];
    assign sda_prev  = sda_sh_q[STAGES];
    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

    // R2: start and stop are never reported in the same cycle
    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

// File: rtl/i2c_gc_match.sv
`timescale 1ns/1ps
module i2c_gc_match
    import i2c_gc_pkg::*;
(
    input  logic [BYTE_W-1:0] cand,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              gc_enable,
    output addr_class_e       cls
);
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    always_comb begin
        cls = CL_NONE;
        if (gc_enable && cand == '0) begin
            cls = CL_GC;
        end else if (!cand[0] && cand[BYTE_W-1:1] == own_addr[BYTE_W-1:1]) begin
            if (!ten_bit) begin
                cls = CL_OWN7;
            end else if (cand[BYTE_W-1:BYTE_W-5] == TEN_PREFIX) begin
                cls = CL_OWN10HI;
            end
        end
    end

endmodule

// File: rtl/i2c_gc_core.sv
`timescale 1ns/1ps
module i2c_gc_core
    import i2c_gc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              buf_rd,
    input  logic              irq_clr,
    input  addr_class_e       cls,
    output logic [BYTE_W-1:0] cand,
    output logic [BYTE_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              irq,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_LOW  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_HIGH = CNT_W'(BYTE_W + 1);

    core_s d, q;
    logic  counting;
    logic  byte_done;
    logic  full_eff;

    assign cand      = {q.shreg[BYTE_W-2:0], sda_lvl};
    assign counting  = (q.phase == ST_ADDR) || (q.phase == ST_ADDR2) || (q.phase == ST_DATA);
    assign byte_done = counting && scl_rise && (q.cnt == LAST_BIT);
    assign full_eff  = q.full && !buf_rd;

    always_comb begin
        d = q;
        d.own_seen = own_addr;
        if (own_addr != q.own_seen) d.ua = 1'b0;
        if (buf_rd) d.full = 1'b0;
        if (irq_clr) begin
            d.irq = 1'b0;
            d.ovf = 1'b0;
        end

        if (counting) begin
            if (scl_rise) begin
                if (q.cnt < ACK_LOW) begin
                    d.shreg = cand;
                    d.cnt   = q.cnt + 1'b1;
                end else if (q.cnt == ACK_LOW) begin
                    d.cnt = ACK_HIGH;
                end
            end else if (scl_fall) begin
                if (q.cnt == ACK_LOW) begin
                    d.oe = q.ack_arm;
                end else if (q.cnt == ACK_HIGH) begin
                    d.oe      = 1'b0;
                    d.cnt     = '0;
                    d.ack_arm = 1'b0;
                    d.irq_arm = 1'b0;
                    if (q.irq_arm) d.irq = 1'b1;
                end
            end
        end

        if (byte_done) begin
            unique case (q.phase)
                ST_ADDR: begin
                    unique case (cls)
                        CL_GC, CL_OWN7: begin
                            d.rxbuf   = cand;
                            d.full    = 1'b1;
                            d.ack_arm = 1'b1;
                            d.irq_arm = 1'b1;
                            d.phase   = ST_DATA;
                        end
                        CL_OWN10HI: begin
                            d.rxbuf   = cand;
                            d.full    = 1'b1;
                            d.ack_arm = 1'b1;
                            d.irq_arm = 1'b1;
                            d.ua      = 1'b1;
                            d.phase   = ST_ADDR2;
                        end
                        default: d.phase = ST_SKIP;
                    endcase
                end
                ST_ADDR2: begin
                    if (cand == own_addr) begin
                        d.rxbuf   = cand;
                        d.full    = 1'b1;
                        d.ack_arm = 1'b1;
                        d.irq_arm = 1'b1;
                        d.phase   = ST_DATA;
                    end else begin
                        d.phase = ST_SKIP;
                    end
                end
                ST_DATA: begin
                    d.irq_arm = 1'b1;
                    if (full_eff) begin
                        d.ovf = 1'b1;
                    end else begin
                        d.rxbuf   = cand;
                        d.full    = 1'b1;
                        d.ack_arm = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (start_det || stop_det) begin
            d.phase   = start_det ? ST_ADDR : ST_IDLE;
            d.cnt     = '0;
            d.oe      = 1'b0;
            d.ack_arm = 1'b0;
            d.irq_arm = 1'b0;
            if (start_det) d.ua = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rx_buf   = q.rxbuf;
    assign buf_full = q.full;
    assign overflow = q.ovf;
    assign upd_addr = q.ua;
    assign irq      = q.irq;
    assign sda_oe   = q.oe;

    // R3: the acknowledge is only applied while the clock is low
    p_ack_on_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R2: the data line is released right after a stop
    p_release_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);

    // R4: an ignored transfer never drives the line
    p_skip_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == ST_SKIP) |-> !sda_oe);

    // R6: the interrupt rises only on a clock fall
    p_irq_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(scl_fall));

    // R8: an overflow leaves the buffer contents alone
    p_no_overflow_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $stable(rx_buf));

    // R9: the update flag appears only in 10-bit mode
    p_ua_tenbit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_addr) |-> ten_bit);

endmodule

// File: rtl/i2c_gc_slave.sv
`timescale 1ns/1ps
module i2c_gc_slave
    import i2c_gc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              gc_enable,
    input  logic              buf_rd,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] rx_buf,
    output logic              buf_full,
    output logic              overflow,
    output logic              upd_addr,
    output logic              irq
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] cand;
    addr_class_e       cls;

    i2c_gc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_gc_match u_match (
        .cand      (cand),
        .own_addr  (own_addr),
        .ten_bit   (ten_bit),
        .gc_enable (gc_enable),
        .cls       (cls)
    );

    i2c_gc_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .own_addr  (own_addr),
        .ten_bit   (ten_bit),
        .buf_rd    (buf_rd),
        .irq_clr   (irq_clr),
        .cls       (cls),
        .cand      (cand),
        .rx_buf    (rx_buf),
        .buf_full  (buf_full),
        .overflow  (overflow),
        .upd_addr  (upd_addr),
        .irq       (irq),
        .sda_oe    (sda_oe)
    );

endmodule

// File: tb/tb_i2c_gc_slave.sv
`timescale 1ns/1ps
module tb_i2c_gc_slave;
    localparam int Q = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] own_addr = 8'h00;
    logic       ten_bit = 1'b0;
    logic       gc_enable = 1'b0;
    logic       buf_rd = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sda_oe;
    logic [7:0] rx_buf;
    logic       buf_full, overflow, upd_addr, irq;
    logic       sda_bus;
    logic       done = 1'b0;
    int         checks = 0;
    int         errors = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_gc_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .own_addr(own_addr), .ten_bit(ten_bit), .gc_enable(gc_enable),
        .buf_rd(buf_rd), .irq_clr(irq_clr), .rx_buf(rx_buf), .buf_full(buf_full),
        .overflow(overflow), .upd_addr(upd_addr), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
        acked = ~sda_bus;
        #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic service();
        @(negedge clk); buf_rd = 1'b1; irq_clr = 1'b1;
        @(negedge clk); buf_rd = 1'b0; irq_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rx_buf", rx_buf, 0);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 upd_addr", upd_addr, 0);
        chk("R1 irq", irq, 0);
        chk("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_seven_bit();
        logic a;
        own_addr = 8'h5A; ten_bit = 1'b0; gc_enable = 1'b0;
        bus_start();
        send_byte(8'h5A, a);
        chk("R3 ack", a, 1);
        chk("R3 rx_buf", rx_buf, 8'h5A);
        chk("R3 buf_full", buf_full, 1);
        chk("R6 irq set", irq, 1);
        @(negedge clk); buf_rd = 1'b1; @(negedge clk); buf_rd = 1'b0; @(negedge clk);
        chk("R7 buf_full clr", buf_full, 0);
        chk("R6 irq held", irq, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
        chk("R6 irq clr", irq, 0);
        send_byte(8'h3C, a);
        chk("R3 data ack", a, 1);
        chk("R3 data buf", rx_buf, 8'h3C);
        chk("R6 data irq", irq, 1);
        service();
        bus_stop();
        chk("R2 released", sda_oe, 0);
    endtask

    task automatic t_no_match();
        logic a;
        bus_start();
        send_byte(8'h40, a);
        chk("R4 ack", a, 0);
        chk("R4 irq", irq, 0);
        chk("R4 buf_full", buf_full, 0);
        chk("R4 rx_buf", rx_buf, 8'h3C);
        send_byte(8'h5A, a);
        chk("R4 skip ack", a, 0);
        chk("R4 skip buf", rx_buf, 8'h3C);
        chk("R4 skip irq", irq, 0);
        bus_stop();
        bus_start();
        send_byte(8'h5B, a);
        chk("R4 read ack", a, 0);
        chk("R4 read full", buf_full, 0);
        bus_stop();
    endtask

    task automatic t_general_call();
        logic a;
        gc_enable = 1'b0;
        bus_start();
        send_byte(8'h00, a);
        chk("R5 gc off ack", a, 0);
        chk("R5 gc off irq", irq, 0);
        bus_stop();
        gc_enable = 1'b1;
        bus_start();
        send_byte(8'h00, a);
        chk("R5 gc ack", a, 1);
        chk("R5 gc buf", rx_buf, 8'h00);
        chk("R5 gc irq", irq, 1);
        service();
        send_byte(8'hA5, a);
        chk("R5 gc data ack", a, 1);
        chk("R5 gc data buf", rx_buf, 8'hA5);
        service();
        bus_stop();
        gc_enable = 1'b0;
    endtask

    task automatic t_overflow();
        logic a;
        bus_start();
        send_byte(8'h5A, a);
        service();
        send_byte(8'h11, a);
        chk("R8 first ack", a, 1);
        @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
        send_byte(8'h22, a);
        chk("R8 nack", a, 0);
        chk("R8 overflow", overflow, 1);
        chk("R8 buf kept", rx_buf, 8'h11);
        chk("R8 irq", irq, 1);
        service();
        chk("R8 ovf clr", overflow, 0);
        bus_stop();
    endtask

    task automatic t_ten_bit();
        logic a;
        ten_bit = 1'b1; own_addr = 8'hF4;
        bus_start();
        send_byte(8'hF4, a);
        chk("R9 hi ack", a, 1);
        chk("R9 ua set", upd_addr, 1);
        chk("R9 hi buf", rx_buf, 8'hF4);
        service();
        chk("R9 ua held", upd_addr, 1);
        own_addr = 8'h37;
        @(negedge clk); @(negedge clk);
        chk("R9 ua clr", upd_addr, 0);
        send_byte(8'h37, a);
        chk("R9 lo ack", a, 1);
        chk("R9 lo buf", rx_buf, 8'h37);
        service();
        send_byte(8'h99, a);
        chk("R9 data ack", a, 1);
        chk("R9 data buf", rx_buf, 8'h99);
        service();
        bus_stop();
        own_addr = 8'hF4;
        bus_start();
        send_byte(8'hF4, a);
        service();
        own_addr = 8'h37;
        send_byte(8'h38, a);
        chk("R9 lo mismatch", a, 0);
        chk("R9 lo mismatch full", buf_full, 0);
        bus_stop();
    endtask

    task automatic t_ten_bit_gc();
        logic a;
        ten_bit = 1'b1; own_addr = 8'hF4; gc_enable = 1'b1;
        bus_start();
        send_byte(8'h00, a);
        chk("R10 gc ack", a, 1);
        chk("R10 ua clear", upd_addr, 0);
        chk("R10 gc buf", rx_buf, 8'h00);
        service();
        send_byte(8'h5C, a);
        chk("R10 data ack", a, 1);
        chk("R10 data buf", rx_buf, 8'h5C);
        chk("R10 ua still", upd_addr, 0);
        service();
        bus_stop();
        gc_enable = 1'b0; ten_bit = 1'b0; own_addr = 8'h5A;
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_bits(8'hF0, 4);
        bus_start();
        send_byte(8'h5A, a);
        chk("R2 restart ack", a, 1);
        chk("R2 restart buf", rx_buf, 8'h5A);
        service();
        send_bits(8'h00, 3);
        bus_stop();
        send_byte(8'h5A, a);
        chk("R2 idle nack", a, 0);
        chk("R2 idle full", buf_full, 0);
        chk("R2 idle irq", irq, 0);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_seven_bit();
        t_no_match();
        t_general_call();
        t_overflow();
        t_ten_bit();
        t_ten_bit_gc();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule